// File: doc/BRIEF.md
# Self-Timed Word-Line Pulse Controller

This block produces the two timing strobes of one memory read: the word-line enable that opens a row, and the sense-amplifier enable that lets the column amplifiers draw current. A set-reset cell opens the pulse when an access strobe is accepted. The pulse closes when a replica column answers. That column is a copy of the slowest column, discharged from a known level. When its answer arrives, every real column has had time to develop its differential. Both strobes therefore last only as long as the array actually needs.

A programmable cycle limit sets the worst-case margin. If the replica never answers, the limit closes the pulse and sets a sticky error flag. The replica column is held in its known state for as long as the word line is off. After each pulse there is one recovery cycle in which the replica is restored and new strobes are refused. Sense enable trails word-line enable by a programmable number of cycles.

Top module: `wl_kill_ctrl`

## Requirements
- R1: After reset, wl_en, sa_en, busy and timeout_err are 0 and replica_hold is 1.
- R2: An acc_start sampled at a clock edge while busy is 0, and without replica_done, raises wl_en right after that edge. wl_en then stays high until a kill.
- R3: A replica_done sampled while wl_en is high drops wl_en at that same edge. If the replica answers during the n-th high cycle, wl_en is high for exactly n cycles.
- R4: Counting the high cycles of wl_en from 1, sa_en is high in cycle k exactly when k > se_delay. sa_en drops together with wl_en and is never high while wl_en is low.
- R5: With no replica answer, wl_en is high for exactly max(max_cycles, 1) cycles.
- R6: timeout_err is set only when the limit closes the pulse, and it stays set until reset. When replica_done arrives in the last allowed cycle, the replica wins and no error is recorded.
- R7: busy is high while wl_en is high and for one recovery cycle after it falls. An acc_start seen while busy is ignored and neither starts nor extends a pulse.
- R8: If acc_start and replica_done arrive together while the block is idle, reset wins: no pulse starts.
- R9: replica_hold is high exactly when wl_en is low.
- R10: A replica_done while the block is idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_start | input | 1 | Access start strobe |
| replica_done | input | 1 | Completion from the replica column |
| max_cycles | input | CNT_W | Longest pulse in cycles (0 acts as 1) |
| se_delay | input | CNT_W | Word-line cycles before sense enable |
| wl_en | output | 1 | Word-line enable |
| sa_en | output | 1 | Sense-amplifier enable |
| busy | output | 1 | Pulse or recovery cycle in progress |
| timeout_err | output | 1 | Sticky limit-kill flag |
| replica_hold | output | 1 | Forces the replica column to its known state |

## Verification
Accesses are run with replica answers at several latencies, from one cycle up to just below the limit. Pulse width and the sense-enable count then separate replica kills from limit kills, and show whether the sense delay is counted from the right cycle. Further runs place the answer exactly on the limit cycle, never send it, or send it late. These show the precedence between the two kill sources, how the error flag is set and that it sticks, and the behaviour of a zero limit. Strobes are also sent during a pulse, during the recovery cycle, together with replica_done, and a stray replica_done is sent while idle. These cases show the refusal rules apart from the set-reset priority.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  typedef enum logic [1:0] {
    KILL_NONE    = 2'd0,
    KILL_REPLICA = 2'd1,
    KILL_LIMIT   = 2'd2
  } kill_cause_e;
endpackage

// File: rtl/wlk_sr_cell.sv
// Set-reset pulse cell; reset dominates set. Tracks the recovery cycle.
module wlk_sr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic active_q,
  output logic recover_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      recover_q <= 1'b0;
    end else begin
      recover_q <= active_q && clr_req;
      if (clr_req)      active_q <= 1'b0;
      else if (set_req) active_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wlk_age_ctr.sv
// Counts high cycles of the pulse, 1 in the first cycle, saturating.
module wlk_age_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  output logic [CNT_W-1:0] age
);
  localparam logic [CNT_W-1:0] AGE_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] AGE_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == AGE_TOP) ? v : v + AGE_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age <= '0;
    else if (load)   age <= AGE_ONE;
    else if (active) age <= sat_inc(age);
  end
endmodule

// File: rtl/wlk_limit_guard.sv
// Worst-case margin: closes the pulse when the limit is reached, records the cause.
module wlk_limit_guard
  import wlk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             replica_done,
  input  logic [CNT_W-1:0] age,
  input  logic [CNT_W-1:0] max_cycles,
  output logic             expire,
  output kill_cause_e      cause,
  output logic             err_q
);
  function automatic logic limit_hit(input logic [CNT_W-1:0] a,
                                     input logic [CNT_W-1:0] lim);
    return (lim == '0) || (a >= lim);
  endfunction

  assign expire = active && limit_hit(age, max_cycles);

  always_comb begin
    if (active && replica_done) cause = KILL_REPLICA;
    else if (expire)            cause = KILL_LIMIT;
    else                        cause = KILL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  err_q <= 1'b0;
    else if (cause == KILL_LIMIT) err_q <= 1'b1;
  end
endmodule

// File: rtl/wlk_sense_gate.sv
// Sense enable: opens once the pulse has lasted more than the delay.
module wlk_sense_gate #(
  parameter int CNT_W = 8
) (
  input  logic             active,
  input  logic [CNT_W-1:0] age,
  input  logic [CNT_W-1:0] se_delay,
  output logic             sa_en
);
  function automatic logic past_delay(input logic [CNT_W-1:0] a,
                                      input logic [CNT_W-1:0] d);
    return a > d;
  endfunction

  assign sa_en = active && past_delay(age, se_delay);
endmodule

// File: rtl/wl_kill_ctrl.sv
module wl_kill_ctrl
  import wlk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_start,
  input  logic             replica_done,
  input  logic [CNT_W-1:0] max_cycles,
  input  logic [CNT_W-1:0] se_delay,
  output logic             wl_en,
  output logic             sa_en,
  output logic             busy,
  output logic             timeout_err,
  output logic             replica_hold
);
  logic             active, recover;
  logic             set_req, clr_req, expire;
  logic             kill_by_limit;
  logic [CNT_W-1:0] age;
  kill_cause_e      cause;

  assign busy          = active || recover;
  assign set_req       = acc_start && !busy;
  assign clr_req       = replica_done || expire;
  assign kill_by_limit = (cause == KILL_LIMIT);

  wlk_sr_cell u_cell (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
    .active_q(active), .recover_q(recover)
  );

  wlk_age_ctr #(.CNT_W(CNT_W)) u_age (
    .clk(clk), .rst_n(rst_n), .load(set_req), .active(active), .age(age)
  );

  wlk_limit_guard #(.CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .active(active), .replica_done(replica_done),
    .age(age), .max_cycles(max_cycles), .expire(expire), .cause(cause),
    .err_q(timeout_err)
  );

  wlk_sense_gate #(.CNT_W(CNT_W)) u_sense (
    .active(active), .age(age), .se_delay(se_delay), .sa_en(sa_en)
  );

  assign wl_en        = active;
  assign replica_hold = !active;
endmodule

// File: rtl/wlk_checker.sv
module wlk_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic replica_done,
  input logic wl_en,
  input logic sa_en,
  input logic busy,
  input logic timeout_err,
  input logic replica_hold,
  input logic kill_by_limit
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_start && !replica_done) |=> wl_en);
  // R3
  replica_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_en && replica_done) |=> !wl_en);
  // R4
  sa_in_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sa_en |-> wl_en);
  // R5
  limit_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_by_limit |=> (timeout_err && !wl_en));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  // R7
  recover_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_en) |-> busy);
  // R7
  ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wl_en && acc_start) |=> !wl_en);
  // R8
  conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_start && replica_done) |=> !wl_en);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replica_hold != wl_en);
endmodule

bind wl_kill_ctrl wlk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .replica_done(replica_done),
  .wl_en(wl_en), .sa_en(sa_en), .busy(busy), .timeout_err(timeout_err),
  .replica_hold(replica_hold), .kill_by_limit(kill_by_limit)
);

// File: tb/wl_kill_ctrl_tb.sv
module wl_kill_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_start = 1'b0;
  logic replica_done = 1'b0;
  logic [CNT_W-1:0] max_cycles = '0;
  logic [CNT_W-1:0] se_delay = '0;
  logic wl_en, sa_en, busy, timeout_err, replica_hold;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wl_kill_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .replica_done(replica_done),
    .max_cycles(max_cycles), .se_delay(se_delay), .wl_en(wl_en), .sa_en(sa_en),
    .busy(busy), .timeout_err(timeout_err), .replica_hold(replica_hold)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_start = 1'b0; replica_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One access with a replica that answers in high cycle lat (0: never).
  // mid_start: cycle in which a second strobe is sent (0: none).
  task automatic run_access(input int lat, input int maxc, input int dly,
                            input int mid_start, input string tag);
    int n = 0, sa_n = 0, first_sa = 0, eff, exp_w, exp_sa;
    bit err_before = timeout_err;
    bit exp_err;
    max_cycles = maxc[CNT_W-1:0];
    se_delay   = dly[CNT_W-1:0];
    eff    = (maxc == 0) ? 1 : maxc;
    exp_w  = (lat != 0 && lat <= eff) ? lat : eff;
    exp_sa = (exp_w > dly) ? exp_w - dly : 0;
    exp_err = err_before || !(lat != 0 && lat <= eff);
    acc_start = 1'b1;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      acc_start = 1'b0;
      replica_done = 1'b0;
      if (wl_en) begin
        n++;
        if (sa_en) begin sa_n++; if (first_sa == 0) first_sa = n; end
        if (replica_hold) check(0, {tag, " R9 hold during pulse"}, 1, 0);
        if (!busy) check(0, {tag, " R7 busy during pulse"}, 0, 1);
        if (n == lat) replica_done = 1'b1;
        if (n == mid_start) acc_start = 1'b1;
      end else begin
        if (sa_en) check(0, {tag, " R4 sa_en without wl_en"}, 1, 0);
        if (n > 0) break;
      end
    end
    check(n == exp_w, {tag, " R3/R5 pulse width"}, n, exp_w);
    check(sa_n == exp_sa, {tag, " R4 sense cycles"}, sa_n, exp_sa);
    if (exp_sa > 0) check(first_sa == dly + 1, {tag, " R4 first sense cycle"}, first_sa, dly + 1);
    check(busy == 1'b1, {tag, " R7 recovery busy"}, busy, 1);
    check(timeout_err == exp_err, {tag, " R6 error flag"}, timeout_err, exp_err);
    @(negedge clk);
    check(!busy && !wl_en && replica_hold, {tag, " R9 idle after recovery"}, busy, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(!wl_en && !sa_en && !busy && !timeout_err, "R1 reset outputs", wl_en + sa_en + busy + timeout_err, 0);
    check(replica_hold == 1'b1, "R1 R9 reset hold", replica_hold, 1);
  endtask

  task automatic t_refused_starts();
    // R7: strobe during pulse and in the recovery cycle
    run_access(6, 20, 1, 3, "R7 mid-pulse");
    repeat (3) begin
      @(negedge clk);
      check(!wl_en, "R7 no second pulse", wl_en, 0);
    end
    max_cycles = 20; se_delay = 0;
    acc_start = 1'b1;
    @(negedge clk); acc_start = 1'b0; replica_done = 1'b1;
    @(negedge clk); replica_done = 1'b0;
    check(!wl_en && busy, "R7 in recovery", wl_en, 0);
    acc_start = 1'b1;
    @(negedge clk); acc_start = 1'b0;
    repeat (3) begin
      check(!wl_en, "R7 recovery strobe ignored", wl_en, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_conflict();
    // R8: set and reset together while idle
    acc_start = 1'b1; replica_done = 1'b1;
    @(negedge clk);
    acc_start = 1'b0; replica_done = 1'b0;
    check(!wl_en && !busy, "R8 conflict no pulse", wl_en, 0);
    @(negedge clk);
    check(!wl_en, "R8 conflict still idle", wl_en, 0);
  endtask

  task automatic t_stray_done();
    // R10: replica_done while idle
    replica_done = 1'b1;
    repeat (3) @(negedge clk);
    replica_done = 1'b0;
    check(!wl_en && !sa_en && !busy && !timeout_err && replica_hold,
          "R10 stray done ignored", wl_en + busy + timeout_err, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_access(5, 20, 2, 0, "R2 R3 basic");
    run_access(1, 20, 0, 0, "R3 one-cycle");
    run_access(7, 20, 9, 0, "R4 long delay");
    t_refused_starts();
    t_conflict();
    t_stray_done();
    run_access(6, 6, 2, 0, "R6 answer on limit");
    run_access(0, 4, 1, 0, "R5 no answer");
    run_access(3, 10, 1, 0, "R6 sticky");
    run_access(0, 0, 0, 0, "R5 zero limit");
    run_access(9, 5, 2, 0, "R5 late answer");
    do_reset();
    check(!timeout_err, "R1 reset clears error", timeout_err, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule